// File: doc/BRIEF.md
# Buffered Serial Peripheral Target Controller

This block is the target (clock-receiving) end of a four-wire serial peripheral link. An external controller drives the serial clock and a select line. Frames of 8 or 16 bits go in on MOSI and out on MISO at the same time. The host side works through a transmit holding buffer and a receive holding buffer. The host therefore never touches the shift register directly: it writes the next outgoing frame whenever the transmit buffer reports empty, and it reads each completed incoming frame from the receive buffer.

All serial inputs are brought into the system clock domain through two-stage synchronisers. Clock edges are found by comparing successive synchronised samples, so the system clock must run at least four times faster than the serial clock. The bit rate is set entirely by the external controller.

A four-state machine sequences each frame:

- `ST_IDLE`: not selected.
- `ST_LOAD`: one cycle that captures the frame and its settings.
- `ST_XFER`: bits are shifted.
- `ST_DONE`: one cycle that hands the received word to the host.

The named transitions are:

- `SELECT`: `ST_IDLE` to `ST_LOAD`, when selected.
- `START`: `ST_LOAD` to `ST_XFER`.
- `LAST_SAMPLE`: `ST_XFER` to `ST_DONE`, on the sampling edge of the final bit.
- `NEXT`: `ST_DONE` to `ST_LOAD`, while still selected.
- `ABORT`: from `ST_LOAD`, `ST_XFER` or `ST_DONE` to `ST_IDLE`, on deselection.

Top module: `spi_tgt_ctrl`

## Requirements
- R1: `cfg_wide`=1 selects 16-bit frames and `cfg_wide`=0 selects 8-bit frames. An 8-bit received word is returned in `rd_data[7:0]` with its upper bits zero.
- R2: `cfg_cpol` gives the idle clock level, and the leading edge is the first edge away from that level. With `cfg_cpha`=0, MOSI is sampled on leading edges and MISO changes on trailing edges. With `cfg_cpha`=1, MISO changes on leading edges and MOSI is sampled on trailing edges.
- R3: `cfg_lsb_first`=1 sends and receives the least significant bit first. `cfg_lsb_first`=0 sends and receives the most significant bit first.
- R4: With `cfg_sw_mode`=0, the block is selected while `sel_n` is low. With `cfg_sw_mode`=1, `sel_n` is ignored and the block is selected while `cfg_sw_sel`=0.
- R5: A `wr_en` pulse stores `wr_data` and clears `tx_empty`. When a frame starts, the buffer is copied into the shift register and `tx_empty` is set.
- R6: After the sampling edge of the last bit, the received word appears on `rd_data` and `rx_full` is set.
- R7: A `rd_en` pulse clears `rx_full`. If a frame completes in the same cycle, `rx_full` stays set.
- R8: `tx_irq` equals `tx_irq_en` AND `tx_empty`, and `rx_irq` equals `rx_irq_en` AND `rx_full`.
- R9: While not selected, `miso_oe`=0 and `miso`=0. Deselecting the block mid-frame discards the partial frame: `rx_full` is not set and the next frame starts from bit 0.
- R10: If the transmit buffer is empty when a frame starts, the previously loaded word is sent again.
- R11: Frame width and bit order are captured at frame start. Changing them mid-frame has no effect on that frame.
- R12: With `cfg_cpha`=0, the first output bit is on `miso`, with `miso_oe`=1, before the first clock edge of the frame.
- R13: With `cfg_enable`=0, the block is never selected, so `miso_oe` stays 0 and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_wide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_sw_mode | input | 1 | 1 = select comes from `cfg_sw_sel` instead of the pin |
| cfg_sw_sel | input | 1 | Software select, 0 = selected |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| rx_irq_en | input | 1 | Receive-full interrupt enable |
| wr_en | input | 1 | Write pulse for the transmit buffer |
| wr_data | input | 16 | Word to transmit |
| rd_en | input | 1 | Read pulse; clears `rx_full` |
| rd_data | output | 16 | Receive buffer contents |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread word |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| sck | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data in |
| sel_n | input | 1 | Select pin, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The hardest situation to reach from the ports is a frame whose settings change while it is in flight: the select line drops after a few bits, or width and bit order are flipped between two clock edges. The bench model of the controller can stop after any bit and can toggle the configuration at a chosen bit index. A complete frame then follows, and its result shows whether stale bits or the new settings leaked in. Random frames, in all four clock modes, both widths and both bit orders, with and without a fresh transmit write, cover the resend path and the interaction between the transmit and receive flags.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } eng_state_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              sel_n_s,
    input  logic              cfg_enable,
    input  logic              cfg_wide,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_sw_mode,
    input  logic              cfg_sw_sel,
    input  logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_word,
    output logic              tx_take,
    output logic              rx_push,
    output logic              miso,
    output logic              miso_oe
);

    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_W - 1);

    eng_state_t state, nxt;

    logic              sck_d;
    logic              rise, fall, lead, trail;
    logic              sample_edge, drive_edge;
    logic              selected;
    logic              last_bit;
    logic              f_wide, f_lsb;
    logic              pend;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] tx_sh, rx_sh, rx_nx, tx_nx;
    logic              out_bit;

    // edge detection on the synchronised clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise        = sck_s & ~sck_d;
    assign fall        = ~sck_s & sck_d;
    assign lead        = cfg_cpol ? fall : rise;
    assign trail       = cfg_cpol ? rise : fall;
    assign sample_edge = cfg_cpha ? trail : lead;
    assign drive_edge  = cfg_cpha ? lead : trail;

    assign selected = cfg_enable & (cfg_sw_mode ? ~cfg_sw_sel : ~sel_n_s);
    assign last_bit = (bit_cnt == (f_wide ? LAST_WIDE : LAST_NARROW));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (selected) nxt = ST_LOAD;                 // SELECT
            ST_LOAD: nxt = selected ? ST_XFER : ST_IDLE;          // START / ABORT
            ST_XFER: begin
                if (!selected)                    nxt = ST_IDLE;  // ABORT
                else if (sample_edge && last_bit) nxt = ST_DONE;  // LAST_SAMPLE
            end
            ST_DONE: nxt = selected ? ST_LOAD : ST_IDLE;          // NEXT / ABORT
            default: nxt = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        miso_oe = 1'b0;
        tx_take = 1'b0;
        rx_push = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOAD: begin
                miso_oe = 1'b1;
                tx_take = selected;
            end
            ST_XFER: miso_oe = 1'b1;
            ST_DONE: begin
                miso_oe = 1'b1;
                rx_push = 1'b1;
            end
            default: ;
        endcase
    end

    // receive shift: where the new bit enters depends on order and width
    always_comb begin
        rx_nx = '0;
        if (!f_lsb) begin
            rx_nx = {rx_sh[DATA_W-2:0], mosi_s};
        end else if (f_wide) begin
            rx_nx = {mosi_s, rx_sh[DATA_W-1:1]};
        end else begin
            rx_nx[NARROW_W-1:0] = {mosi_s, rx_sh[NARROW_W-1:1]};
        end
    end

    assign tx_nx   = f_lsb ? (tx_sh >> 1) : (tx_sh << 1);
    assign out_bit = f_lsb ? tx_sh[0]
                   : (f_wide ? tx_sh[DATA_W-1] : tx_sh[NARROW_W-1]);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            pend    <= 1'b0;
            f_wide  <= 1'b0;
            f_lsb   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    pend    <= 1'b0;
                end
                ST_LOAD: begin
                    tx_sh   <= tx_word;
                    rx_sh   <= '0;
                    f_wide  <= cfg_wide;
                    f_lsb   <= cfg_lsb_first;
                    bit_cnt <= '0;
                    pend    <= 1'b0;
                end
                ST_XFER: begin
                    if (sample_edge) begin
                        rx_sh   <= rx_nx;
                        bit_cnt <= bit_cnt + 1'b1;
                        pend    <= 1'b1;
                    end else if (drive_edge && pend) begin
                        tx_sh <= tx_nx;
                        pend  <= 1'b0;
                    end
                end
                ST_DONE: pend <= 1'b0;
                default: ;
            endcase
        end
    end

    assign rx_word = rx_sh;
    assign miso    = miso_oe & out_bit;

endmodule

// File: rtl/spi_tgt_hostbuf.sv
module spi_tgt_hostbuf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              tx_take,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              tx_irq,
    output logic              rx_irq
);

    logic [DATA_W-1:0] tx_buf, rx_buf;
    logic              tx_full;

    // transmit holding buffer: keeps its word after the copy, for resend
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else begin
            if (wr_en) begin
                tx_buf  <= wr_data;
                tx_full <= 1'b1;
            end else if (tx_take) begin
                tx_full <= 1'b0;
            end
        end
    end

    // receive holding buffer: push beats read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else begin
            if (rx_push) begin
                rx_buf  <= rx_word;
                rx_full <= 1'b1;
            end else if (rd_en) begin
                rx_full <= 1'b0;
            end
        end
    end

    assign tx_word  = tx_buf;
    assign rd_data  = rx_buf;
    assign tx_empty = ~tx_full;
    assign tx_irq   = tx_irq_en & ~tx_full;
    assign rx_irq   = rx_irq_en & rx_full;

endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_wide,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_sw_mode,
    input  logic              cfg_sw_sel,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              sck,
    input  logic              mosi,
    input  logic              sel_n,
    output logic              miso,
    output logic              miso_oe
);

    logic [2:0]        pins_s;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic              tx_take, rx_push;

    spi_tgt_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_N),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck, mosi, sel_n}),
        .dout  (pins_s)
    );

    spi_tgt_engine #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_s         (pins_s[2]),
        .mosi_s        (pins_s[1]),
        .sel_n_s       (pins_s[0]),
        .cfg_enable    (cfg_enable),
        .cfg_wide      (cfg_wide),
        .cfg_cpol      (cfg_cpol),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_sw_mode   (cfg_sw_mode),
        .cfg_sw_sel    (cfg_sw_sel),
        .tx_word       (tx_word),
        .rx_word       (rx_word),
        .tx_take       (tx_take),
        .rx_push       (rx_push),
        .miso          (miso),
        .miso_oe       (miso_oe)
    );

    spi_tgt_hostbuf #(
        .DATA_W (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .tx_take   (tx_take),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .tx_irq_en (tx_irq_en),
        .rx_irq_en (rx_irq_en),
        .tx_word   (tx_word),
        .rd_data   (rd_data),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full),
        .tx_irq    (tx_irq),
        .rx_irq    (rx_irq)
    );

endmodule

// File: rtl/spi_tgt_checker.sv
module spi_tgt_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic miso_oe,
    input logic miso,
    input logic wr_en,
    input logic tx_take,
    input logic tx_empty,
    input logic rd_en,
    input logic rx_push,
    input logic rx_full
);

    assert_oe_needs_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> $past(cfg_enable))
        else $error("R13: output enabled without enable");

    assert_idle_miso_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso)
        else $error("R9: miso not low while idle");

    assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty)
        else $error("R5: write did not fill buffer");

    assert_take_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !wr_en) |=> tx_empty)
        else $error("R5: frame start did not empty buffer");

    assert_push_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> rx_full)
        else $error("R6: completed frame did not set rx_full");

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_push) |=> !rx_full)
        else $error("R7: read did not clear rx_full");

endmodule

bind spi_tgt_ctrl spi_tgt_checker u_chk (.*);

// File: tb/spi_tgt_ctrl_bench.sv
module spi_tgt_ctrl_bench;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_wide = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic        cfg_lsb_first = 1'b0, cfg_sw_mode = 1'b0, cfg_sw_sel = 1'b1;
    logic        tx_irq_en = 1'b0, rx_irq_en = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        tx_empty, rx_full, tx_irq, rx_irq;
    logic        sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
    logic        miso, miso_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_tgt_ctrl u_spi_tgt_ctrl (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_w(input bit wide, input logic [15:0] v);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

    function automatic logic first_bit(input bit wide, input bit lsb, input logic [15:0] v);
        return lsb ? v[0] : (wide ? v[15] : v[7]);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_mode(input bit cpol, input bit cpha);
        cfg_cpol = cpol; cfg_cpha = cpha; sck = cpol;
        cyc(6);
    endtask

    // controller model; stops after nstop bits, flips width/order at bit chg_at
    task automatic do_frame(input bit wide, input bit lsb, input logic [15:0] mo,
                            input int nstop, input int chg_at, output logic [15:0] mi);
        int nb;
        nb = wide ? 16 : 8;
        mi = '0;
        for (int i = 0; i < nb && i < nstop; i++) begin
            int idx;
            idx = lsb ? i : nb - 1 - i;
            if (i == chg_at) begin
                cfg_wide = ~cfg_wide; cfg_lsb_first = ~cfg_lsb_first;
            end
            if (!cfg_cpha) begin
                mosi = mo[idx];
                cyc(HALF);
                mi[idx] = miso;
                sck = ~cfg_cpol;
                cyc(HALF);
                sck = cfg_cpol;
            end else begin
                sck = ~cfg_cpol;
                mosi = mo[idx];
                cyc(HALF);
                mi[idx] = miso;
                sck = cfg_cpol;
                cyc(HALF);
            end
        end
        cyc(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] mi, last_tx, d, mo;
        void'($urandom(32'd1234));
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // reset state
        chk("R5 reset tx_empty", {15'd0, tx_empty}, 16'd1);
        chk("R6 reset rx_full", {15'd0, rx_full}, 16'd0);
        chk("R9 reset miso_oe", {15'd0, miso_oe}, 16'd0);
        chk("R13 disabled stays idle", {15'd0, miso_oe}, 16'd0);

        // mode 0, 8-bit, MSB first
        cfg_enable = 1'b1;
        set_mode(1'b0, 1'b0);
        tx_irq_en = 1'b1;
        host_write(16'h00A5);
        chk("R5 write clears tx_empty", {15'd0, tx_empty}, 16'd0);
        chk("R8 tx_irq low when full", {15'd0, tx_irq}, 16'd0);
        sel_n = 1'b0; cyc(8);
        chk("R5 frame start sets tx_empty", {15'd0, tx_empty}, 16'd1);
        chk("R8 tx_irq follows empty", {15'd0, tx_irq}, 16'd1);
        chk("R12 first bit before edge", {14'd0, miso_oe, miso}, 16'd3);
        do_frame(1'b0, 1'b0, 16'h003C, 99, -1, mi);
        chk("R1 R2 narrow miso word", mask_w(0, mi), 16'h00A5);
        chk("R6 rx_full set", {15'd0, rx_full}, 16'd1);
        chk("R6 R1 rd_data narrow", rd_data, 16'h003C);
        chk("R8 rx_irq off when disabled", {15'd0, rx_irq}, 16'd0);
        rx_irq_en = 1'b1; cyc(1);
        chk("R8 rx_irq on", {15'd0, rx_irq}, 16'd1);
        host_read();
        chk("R7 read clears rx_full", {15'd0, rx_full}, 16'd0);
        sel_n = 1'b1; cyc(6);
        chk("R9 deselect drops oe", {14'd0, miso_oe, miso}, 16'd0);

        // mode 3, 16-bit, LSB first
        cfg_wide = 1'b1; cfg_lsb_first = 1'b1;
        set_mode(1'b1, 1'b1);
        host_write(16'h1234);
        sel_n = 1'b0; cyc(8);
        do_frame(1'b1, 1'b1, 16'hBEEF, 99, -1, mi);
        chk("R3 R2 lsb wide miso", mi, 16'h1234);
        chk("R3 lsb wide rx", rd_data, 16'hBEEF);
        host_read();
        sel_n = 1'b1; cyc(6);

        // resend when buffer empty
        sel_n = 1'b0; cyc(8);
        do_frame(1'b1, 1'b1, 16'h0F0F, 99, -1, mi);
        chk("R10 resend last word", mi, 16'h1234);
        host_read();
        sel_n = 1'b1; cyc(6);

        // partial frame then deselect
        cfg_wide = 1'b0; cfg_lsb_first = 1'b0;
        set_mode(1'b0, 1'b1);
        host_write(16'h0081);
        sel_n = 1'b0; cyc(8);
        do_frame(1'b0, 1'b0, 16'h00FF, 5, -1, mi);
        sel_n = 1'b1; cyc(6);
        chk("R9 partial not received", {15'd0, rx_full}, 16'd0);
        sel_n = 1'b0; cyc(8);
        do_frame(1'b0, 1'b0, 16'h0066, 99, -1, mi);
        chk("R9 frame after abort rx", rd_data, 16'h0066);
        chk("R9 frame after abort miso", mask_w(0, mi), 16'h0081);
        host_read();
        sel_n = 1'b1; cyc(6);

        // software select
        cfg_sw_mode = 1'b1; cfg_sw_sel = 1'b1;
        sel_n = 1'b0; cyc(8);
        chk("R4 pin ignored in sw mode", {15'd0, miso_oe}, 16'd0);
        sel_n = 1'b1; cfg_sw_sel = 1'b0; cyc(8);
        chk("R4 sw select active", {15'd0, miso_oe}, 16'd1);
        do_frame(1'b0, 1'b0, 16'h00C3, 99, -1, mi);
        chk("R4 sw select frame rx", rd_data, 16'h00C3);
        host_read();
        cfg_sw_sel = 1'b1; cfg_sw_mode = 1'b0; cyc(6);

        // disabled
        cfg_enable = 1'b0;
        sel_n = 1'b0; cyc(8);
        chk("R13 disabled no oe", {15'd0, miso_oe}, 16'd0);
        do_frame(1'b0, 1'b0, 16'h0055, 99, -1, mi);
        chk("R13 disabled no rx", {15'd0, rx_full}, 16'd0);
        sel_n = 1'b1; cfg_enable = 1'b1; cyc(6);

        // mid-frame change of width and order
        set_mode(1'b0, 1'b0);
        host_write(16'h004E);
        sel_n = 1'b0; cyc(8);
        do_frame(1'b0, 1'b0, 16'h0099, 99, 3, mi);
        chk("R11 mid-frame change rx", rd_data, 16'h0099);
        chk("R11 mid-frame change miso", mask_w(0, mi), 16'h004E);
        host_read();
        sel_n = 1'b1; cyc(6);
        cfg_wide = 1'b0; cfg_lsb_first = 1'b0;

        // random frames
        last_tx = 16'h004E;
        for (int k = 0; k < 24; k++) begin
            bit w, l, wr;
            d  = 16'($urandom);
            mo = 16'($urandom);
            w  = 1'($urandom); l = 1'($urandom); wr = 1'($urandom);
            cfg_wide = w; cfg_lsb_first = l;
            set_mode(1'($urandom), 1'($urandom));
            if (wr) begin
                host_write(d);
                last_tx = d;
            end
            sel_n = 1'b0; cyc(8);
            if (!cfg_cpha)
                chk("R12 random first bit", {15'd0, miso}, {15'd0, first_bit(w, l, last_tx)});
            do_frame(w, l, mo, 99, -1, mi);
            chk("R1 R2 R3 random miso", mask_w(w, mi), mask_w(w, last_tx));
            chk("R1 R3 R6 random rx", rd_data, mask_w(w, mo));
            host_read();
            chk("R7 random read clear", {15'd0, rx_full}, 16'd0);
            sel_n = 1'b1; cyc(6);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule